// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block brings a board crystal oscillator and the PLL that runs from it up or down in a fixed order. A one-cycle request names the crystal, the PLL or both, together with a direction. The block drives a crystal power-up bit, an active-high PLL power-down bit and one output-enable bit per resource, in that order. Between steps it waits out settle times that are counted in clock cycles. When the sequence is complete it raises a one-cycle done.

On every power-up request the block also pulses a clear for a sticky target-abort status flag. A live readback of the crystal power bit protects a clock that another user may already be running. If that readback is high when a power-up is accepted, all output changes are skipped and only the status clear and done are produced. While a sequence runs, the block holds busy high and ignores any further requests.

Top module: `osc_pwr_seq`

## Requirements
- R1: After reset all four control outputs, busy, done and the status clear are 0.
- R2: Every request that updates the pins sets the output enable of each named resource (xtal_oe_o for the crystal, pll_oe_o for the PLL). An enable, once set, is never cleared.
- R3: A power-up accepted while xtal_sense_i is 1 changes no control output. It gives done in the cycle after acceptance.
- R4: A power-up that names the crystal drives xtal_pu_o to 1 at the acceptance edge. If the PLL is also named, pll_pd_o goes to 1 at the same edge.
- R5: After the crystal comes up, pll_pd_o stays 1 for XTAL_SETTLE_CYC cycles before it is cleared. A crystal-only power-up gives done XTAL_SETTLE_CYC cycles after acceptance.
- R6: Enabling the PLL clears pll_pd_o to 0, and done follows PLL_SETTLE_CYC cycles after that clear. For a PLL-only power-up the clear happens at the acceptance edge.
- R7: A power-down makes a single update at the acceptance edge. It clears xtal_pu_o if the crystal is named and sets pll_pd_o if the PLL is named. Done follows in the next cycle.
- R8: abort_clr_o pulses together with done for every power-up request, including skipped and empty ones. It never pulses for a power-down.
- R9: busy_o is high from the cycle after acceptance through the done cycle. Requests that arrive while busy_o is high have no effect.
- R10: A request that names neither resource leaves all control outputs unchanged and gives done in the next cycle.
- R11: done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, accepted when not busy |
| req_xtal_i | input | 1 | Request names the crystal |
| req_pll_i | input | 1 | Request names the PLL |
| req_on_i | input | 1 | 1 = power up, 0 = power down |
| xtal_sense_i | input | 1 | Readback of the crystal power bit |
| xtal_pu_o | output | 1 | Crystal power-up control bit |
| pll_pd_o | output | 1 | PLL power-down control bit (active high) |
| xtal_oe_o | output | 1 | Output enable of the crystal bit |
| pll_oe_o | output | 1 | Output enable of the PLL bit |
| abort_clr_o | output | 1 | One-cycle clear of the target-abort status flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a running power-up. It must leave the crystal bit, the PLL bit and the done count untouched. The stimulus provokes it by injecting a full power-down one cycle into a crystal-plus-PLL sequence, then checking the pins right away and again when the single expected done arrives. The settle window is checked around its edge: pll_pd_o must still be high in the last counted cycle and low in the next. The skip path is forced by raising the crystal readback before a power-up.

// File: rtl/osc_pwr_pkg.sv
package osc_pwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XWAIT = 2'd1,
    ST_PWAIT = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic xtal;
    logic pll;
    logic on;
  } pwr_req_t;

  typedef struct packed {
    logic oe_xtal;
    logic oe_pll;
    logic xtal_set;
    logic xtal_clr;
    logic pd_set;
    logic pd_clr;
  } pin_cmd_t;

endpackage

// File: rtl/osc_pwr_timer.sv
module osc_pwr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (!zero_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/osc_pwr_pins.sv
module osc_pwr_pins
  import osc_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cmd_t cmd_i,
  output logic     xtal_pu_o,
  output logic     pll_pd_o,
  output logic     xtal_oe_o,
  output logic     pll_oe_o
);

  logic xtal_q, pd_q, oex_q, oep_q;
  logic xtal_d, pd_d, oex_d, oep_d;
  logic upd_en;

  assign upd_en = |cmd_i;

  always_comb begin
    xtal_d = xtal_q;
    if (cmd_i.xtal_set)      xtal_d = 1'b1;
    else if (cmd_i.xtal_clr) xtal_d = 1'b0;
    pd_d = pd_q;
    if (cmd_i.pd_set)        pd_d = 1'b1;
    else if (cmd_i.pd_clr)   pd_d = 1'b0;
    oex_d = oex_q | cmd_i.oe_xtal;
    oep_d = oep_q | cmd_i.oe_pll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q <= 1'b0;
      pd_q   <= 1'b0;
      oex_q  <= 1'b0;
      oep_q  <= 1'b0;
    end else if (upd_en) begin
      xtal_q <= xtal_d;
      pd_q   <= pd_d;
      oex_q  <= oex_d;
      oep_q  <= oep_d;
    end
  end

  assign xtal_pu_o = xtal_q;
  assign pll_pd_o  = pd_q;
  assign xtal_oe_o = oex_q;
  assign pll_oe_o  = oep_q;

endmodule

// File: rtl/osc_pwr_ctrl.sv
module osc_pwr_ctrl
  import osc_pwr_pkg::*;
#(
  parameter int XTAL_SETTLE_CYC = 64,
  parameter int PLL_SETTLE_CYC  = 320,
  parameter int CW              = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  pwr_req_t      req_i,
  input  logic          xtal_sense_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output pin_cmd_t      cmd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_clr_o
);

  localparam logic [CW-1:0] XWAIT_LOAD = CW'(XTAL_SETTLE_CYC - 1);
  localparam logic [CW-1:0] PWAIT_LOAD = CW'(PLL_SETTLE_CYC - 1);

  seq_state_e state_q, state_d;
  logic       pll_q, on_q;
  logic       accept;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cmd_o      = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_i.xtal && !req_i.pll) begin
            state_d = ST_FIN;
          end else if (!req_i.on) begin
            cmd_o.oe_xtal  = req_i.xtal;
            cmd_o.oe_pll   = req_i.pll;
            cmd_o.xtal_clr = req_i.xtal;
            cmd_o.pd_set   = req_i.pll;
            state_d        = ST_FIN;
          end else if (xtal_sense_i) begin
            state_d = ST_FIN;
          end else if (req_i.xtal) begin
            cmd_o.oe_xtal  = 1'b1;
            cmd_o.oe_pll   = req_i.pll;
            cmd_o.xtal_set = 1'b1;
            cmd_o.pd_set   = req_i.pll;
            tmr_load_o     = 1'b1;
            tmr_val_o      = XWAIT_LOAD;
            state_d        = ST_XWAIT;
          end else begin
            cmd_o.oe_pll = 1'b1;
            cmd_o.pd_clr = 1'b1;
            tmr_load_o   = 1'b1;
            tmr_val_o    = PWAIT_LOAD;
            state_d      = ST_PWAIT;
          end
        end
      end
      ST_XWAIT: begin
        if (tmr_zero_i) begin
          if (pll_q) begin
            cmd_o.pd_clr = 1'b1;
            tmr_load_o   = 1'b1;
            tmr_val_o    = PWAIT_LOAD;
            state_d      = ST_PWAIT;
          end else begin
            state_d = ST_FIN;
          end
        end
      end
      ST_PWAIT: begin
        if (tmr_zero_i) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q <= 1'b0;
      on_q  <= 1'b0;
    end else if (accept) begin
      pll_q <= req_i.pll;
      on_q  <= req_i.on;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign abort_clr_o = (state_q == ST_FIN) && on_q;

endmodule

// File: rtl/osc_pwr_seq.sv
module osc_pwr_seq
  import osc_pwr_pkg::*;
#(
  parameter int XTAL_SETTLE_CYC = 64,
  parameter int PLL_SETTLE_CYC  = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic req_xtal_i,
  input  logic req_pll_i,
  input  logic req_on_i,
  input  logic xtal_sense_i,
  output logic xtal_pu_o,
  output logic pll_pd_o,
  output logic xtal_oe_o,
  output logic pll_oe_o,
  output logic abort_clr_o,
  output logic busy_o,
  output logic done_o
);

  localparam int MAX_CYC = (XTAL_SETTLE_CYC > PLL_SETTLE_CYC) ? XTAL_SETTLE_CYC
                                                               : PLL_SETTLE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  pwr_req_t      req;
  pin_cmd_t      cmd;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  assign req.xtal = req_xtal_i;
  assign req.pll  = req_pll_i;
  assign req.on   = req_on_i;

  osc_pwr_ctrl #(
    .XTAL_SETTLE_CYC(XTAL_SETTLE_CYC),
    .PLL_SETTLE_CYC (PLL_SETTLE_CYC),
    .CW             (CW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_i       (req),
    .xtal_sense_i(xtal_sense_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cmd_o       (cmd),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .abort_clr_o (abort_clr_o)
  );

  osc_pwr_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  osc_pwr_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd),
    .xtal_pu_o(xtal_pu_o),
    .pll_pd_o (pll_pd_o),
    .xtal_oe_o(xtal_oe_o),
    .pll_oe_o (pll_oe_o)
  );

endmodule

// File: rtl/osc_pwr_seq_chk.sv
module osc_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid_i,
  input logic req_xtal_i,
  input logic req_pll_i,
  input logic req_on_i,
  input logic xtal_sense_i,
  input logic xtal_pu_o,
  input logic pll_pd_o,
  input logic xtal_oe_o,
  input logic pll_oe_o,
  input logic abort_clr_o,
  input logic busy_o,
  input logic done_o
);

  a_r2_xtal_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_oe_o |=> xtal_oe_o);

  a_r2_pll_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pll_oe_o |=> pll_oe_o);

  a_r3_skip_keeps_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_valid_i && req_on_i && xtal_sense_i)
      |=> ($stable(xtal_pu_o) && $stable(pll_pd_o) && done_o));

  a_r7_off_clears_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_valid_i && !req_on_i && req_xtal_i) |=> (!xtal_pu_o && done_o));

  a_r7_off_sets_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_valid_i && !req_on_i && req_pll_i) |=> pll_pd_o);

  a_r8_clr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr_o |-> done_o);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r10_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_valid_i && !req_xtal_i && !req_pll_i)
      |=> (done_o && $stable(xtal_pu_o) && $stable(pll_pd_o)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind osc_pwr_seq osc_pwr_seq_chk i_osc_pwr_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_xtal_i  (req_xtal_i),
  .req_pll_i   (req_pll_i),
  .req_on_i    (req_on_i),
  .xtal_sense_i(xtal_sense_i),
  .xtal_pu_o   (xtal_pu_o),
  .pll_pd_o    (pll_pd_o),
  .xtal_oe_o   (xtal_oe_o),
  .pll_oe_o    (pll_oe_o),
  .abort_clr_o (abort_clr_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_osc_pwr_seq.sv
module test_osc_pwr_seq;

  localparam int XC = 20;
  localparam int PC = 50;

  logic clk, rst_n;
  logic req_valid, req_xtal, req_pll, req_on, sense;
  logic xtal_pu, pll_pd, xtal_oe, pll_oe, abort_clr, busy, done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  typedef struct {
    int         start;
    int         lat;
    logic       xt;
    logic       pd;
    logic [1:0] oe;
    logic       clr;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  logic       m_xt, m_pd;
  logic [1:0] m_oe;

  osc_pwr_seq #(.XTAL_SETTLE_CYC(XC), .PLL_SETTLE_CYC(PC)) i_osc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_xtal_i(req_xtal),
    .req_pll_i(req_pll), .req_on_i(req_on), .xtal_sense_i(sense),
    .xtal_pu_o(xtal_pu), .pll_pd_o(pll_pd), .xtal_oe_o(xtal_oe), .pll_oe_o(pll_oe),
    .abort_clr_o(abort_clr), .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // Monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(cyc - e.start == e.lat, {e.tag, " latency"}, cyc - e.start, e.lat);
        chk(xtal_pu == e.xt, {e.tag, " xtal_pu"}, xtal_pu, e.xt);
        chk(pll_pd == e.pd, {e.tag, " pll_pd"}, pll_pd, e.pd);
        chk({xtal_oe, pll_oe} == e.oe, {e.tag, " R2 enables"}, {xtal_oe, pll_oe}, e.oe);
        chk(abort_clr == e.clr, {e.tag, " R8 abort_clr"}, abort_clr, e.clr);
      end
    end
  end

  task automatic send(input bit x, input bit p, input bit on, input bit intrude,
                      input string tag);
    exp_t e;
    bool_probe: begin end
    e.lat = 0;
    if (!x && !p) begin
    end else if (!on) begin
      m_oe = m_oe | {x, p};
      if (x) m_xt = 1'b0;
      if (p) m_pd = 1'b1;
    end else if (sense) begin
    end else if (x) begin
      m_oe  = m_oe | {1'b1, p};
      m_xt  = 1'b1;
      if (p) m_pd = 1'b0;
      e.lat = XC + (p ? PC : 0);
    end else begin
      m_oe  = m_oe | 2'b01;
      m_pd  = 1'b0;
      e.lat = PC;
    end
    e.xt  = m_xt;
    e.pd  = m_pd;
    e.oe  = m_oe;
    e.clr = on;
    e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_xtal = x; req_pll = p; req_on = on;
    @(posedge clk);
    #1;
    e.start = cyc;
    sbq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (on && x && !sense) begin
      chk(xtal_pu == 1'b1, "R4 crystal bit up", xtal_pu, 1);
      chk(pll_pd == p, "R4 pll held down with crystal", pll_pd, p);
      if (p) begin
        if (intrude) begin
          req_valid = 1'b1; req_xtal = 1'b1; req_pll = 1'b1; req_on = 1'b0;
          @(negedge clk);
          req_valid = 1'b0;
          chk(xtal_pu == 1'b1 && busy, "R9 request ignored while busy", xtal_pu, 1);
          repeat (XC - 2) @(negedge clk);
        end else begin
          repeat (XC - 1) @(negedge clk);
        end
        chk(pll_pd == 1'b1, "R5 pll down through settle window", pll_pd, 1);
        @(negedge clk);
        chk(pll_pd == 1'b0, "R6 pll enabled after settle", pll_pd, 0);
      end
    end
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R11 done single pulse, busy low", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_xtal = 1'b0; req_pll = 1'b0;
    req_on = 1'b0; sense = 1'b0;
    m_xt = 1'b0; m_pd = 1'b0; m_oe = 2'b00;
    repeat (3) @(negedge clk);
    chk({xtal_pu, pll_pd, xtal_oe, pll_oe, abort_clr, busy, done} == 7'b0,
        "R1 reset state", {xtal_pu, pll_pd, xtal_oe, pll_oe, abort_clr, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(1'b0, 1'b0, 1'b1, 1'b0, "R10 empty on request");
    send(1'b0, 1'b0, 1'b0, 1'b0, "R10 empty off request");
    send(1'b0, 1'b1, 1'b1, 1'b0, "R6 pll-only power-up");
    send(1'b1, 1'b1, 1'b0, 1'b0, "R7 power-down both");
    send(1'b1, 1'b1, 1'b1, 1'b0, "R5 power-up both");
    send(1'b1, 1'b1, 1'b0, 1'b0, "R7 power-down both again");
    send(1'b1, 1'b1, 1'b1, 1'b1, "R9 power-up with intrusion");
    sense = 1'b1;
    send(1'b1, 1'b1, 1'b1, 1'b0, "R3 skipped power-up");
    send(1'b1, 1'b0, 1'b0, 1'b0, "R7 crystal-only power-down");
    sense = 1'b0;
    send(1'b1, 1'b0, 1'b1, 1'b0, "R5 crystal-only power-up");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule